// File: doc/BRIEF.md
# Warp Memory Address Coalescer

This block takes one memory request from a warp and reduces it to the smallest set of aligned line transactions. A request is a vector of per-lane byte addresses, an active-lane mask and a flag that marks it as a store (scatter) rather than a load (gather). Every distinct aligned line touched by the active lanes becomes exactly one outgoing transaction. That transaction carries the line number and a mask of the lanes whose addresses fall inside that line. A request whose lanes walk through memory with one element step, or with any constant step, collapses into as few lines as the stride allows. An irregular address set falls back to one transaction per distinct line.

Requests enter through a valid/ready port into a small in-order request queue. This lets a new warp request wait while the previous one is still being split. A four-state engine drives the work. ST_IDLE pops the queue head into working registers when the queue is not empty. ST_LOAD classifies the access pattern; it goes to ST_FINISH when no lane is active and to ST_EMIT otherwise. ST_EMIT offers one transaction per cycle on a valid/ready port and retires the lanes that were accepted. It moves to ST_FINISH once the last pending lane is accepted. ST_FINISH raises a one-cycle completion pulse and returns to ST_IDLE. Every transaction also carries a pattern label for the whole request, which downstream banks can use to choose a wide or a narrow access.

Top module: `acu_top`

## Requirements
- R1: `in_ready` is high exactly when the request queue holds fewer than FIFO_DEPTH (default 2) requests. A request already taken by the engine does not count. Requests are served in arrival order.
- R2: Exactly one transaction is emitted for each distinct line touched by the active lanes. The line is the address shifted right by log2(LINE_BYTES), 5 bits by default. `out_lanes` is the set of active lanes whose address lies in that line.
- R3: A lane whose `in_mask` bit is 0 is ignored: its address changes neither the transactions nor the pattern label.
- R4: Transactions of one request leave in ascending order of the lowest lane index they contain.
- R5: `out_kind` labels the request. 2'd1 means a sequential pattern: fewer than two active lanes, or consecutive active lanes (in lane order) step by exactly ELEM_BYTES (default 4). 2'd3 means all active addresses are equal. 2'd2 means any other constant step between consecutive active lanes. 2'd0 means irregular.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_line`, `out_lanes`, `out_kind` and `out_store` hold their values into the next cycle.
- R7: `done` is high for exactly one cycle, in the cycle after the last transaction of a request is accepted, and never together with `out_valid`. A request with no active lane produces no transaction and still produces one `done` pulse.
- R8: `out_store` equals the `in_store` value of the request the transaction belongs to.
- R9: After reset, `out_valid` and `done` are low and `in_ready` is high.
- R10: `out_lanes` is never zero while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Warp request offered |
| in_ready | output | 1 | Request queue has room |
| in_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane i in bits [i*ADDR_W +: ADDR_W] |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| in_store | input | 1 | 1 for scatter (store), 0 for gather (load) |
| out_valid | output | 1 | Line transaction offered |
| out_ready | input | 1 | Downstream takes the transaction |
| out_line | output | ADDR_W-log2(LINE_BYTES) | Aligned line number |
| out_lanes | output | LANES | Lanes served by this transaction |
| out_kind | output | 2 | Pattern label of the request |
| out_store | output | 1 | Store flag of the request |
| done | output | 1 | One-cycle pulse after the last transaction of a request |

## Verification
The hardest state to reach from the ports is a full request queue behind an engine stalled in the middle of a request. Reaching it also proves that `in_ready` falls and that the queued requests later leave in order with their own store flags. The bench holds `out_ready` low before offering three requests back to back, so the first sits in ST_EMIT while the other two fill the queue. The bench then checks `in_ready` and releases the output. A second hard case is the hold rule under random backpressure: a pseudo-random ready pattern runs across a many-line strided request, and the bench compares every stalled cycle against the previous one.

// File: rtl/acu_pkg.sv
package acu_pkg;

    // Pattern label carried with every transaction of a request
    typedef enum logic [1:0] {
        KIND_IRREG  = 2'd0,
        KIND_SEQ    = 2'd1,
        KIND_STRIDE = 2'd2,
        KIND_SAME   = 2'd3
    } acu_kind_e;

    // Engine states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_EMIT   = 2'd2,
        ST_FINISH = 2'd3
    } acu_state_e;

endpackage

// File: rtl/acu_req_fifo.sv
module acu_req_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    output logic             push_ready,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_en,
    output logic [WIDTH-1:0] pop_data,
    output logic             not_empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_fire, pop_fire;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ready = (count != CNT_W'(DEPTH));
    assign not_empty  = (count != '0);
    assign push_fire  = push_valid && push_ready;
    assign pop_fire   = pop_en && not_empty;
    assign pop_data   = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_fire) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_fire) wr_ptr <= bump(wr_ptr);
            if (pop_fire)  rd_ptr <= bump(rd_ptr);
            unique case ({push_fire, pop_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/acu_classify.sv
module acu_classify
    import acu_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int ADDR_W     = 16,
    parameter int ELEM_BYTES = 4
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        mask,
    output acu_kind_e               kind
);
    logic              seen_one, seen_two, uniform;
    logic [ADDR_W-1:0] base, second, step, want;

    // Walk the active lanes in lane order, checking one constant step
    always_comb begin
        seen_one = 1'b0;
        seen_two = 1'b0;
        base     = '0;
        second   = '0;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                if (!seen_one) begin
                    base     = addr_flat[i*ADDR_W +: ADDR_W];
                    seen_one = 1'b1;
                end else if (!seen_two) begin
                    second   = addr_flat[i*ADDR_W +: ADDR_W];
                    seen_two = 1'b1;
                end
            end
        end
        step    = second - base;
        want    = base;
        uniform = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
                if (addr_flat[i*ADDR_W +: ADDR_W] != want) uniform = 1'b0;
                want = want + step;
            end
        end
        if (!seen_two)                             kind = KIND_SEQ;
        else if (!uniform)                         kind = KIND_IRREG;
        else if (step == ADDR_W'(ELEM_BYTES))      kind = KIND_SEQ;
        else if (step == '0)                       kind = KIND_SAME;
        else                                       kind = KIND_STRIDE;
    end

endmodule

// File: rtl/acu_group.sv
module acu_group #(
    parameter int LANES  = 8,
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 5
) (
    input  logic [LANES*ADDR_W-1:0] addr_flat,
    input  logic [LANES-1:0]        pending,
    output logic [ADDR_W-OFF_W-1:0] line,
    output logic [LANES-1:0]        lanes
);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic                  found;
    logic [ADDR_W-1:0]     lane_addr [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_addr[g] = addr_flat[g*ADDR_W +: ADDR_W];
    end

    // Lowest pending lane leads; every pending lane in its line joins
    always_comb begin
        found = 1'b0;
        line  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && !found) begin
                line  = lane_addr[i][ADDR_W-1:OFF_W];
                found = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_match
        assign lanes[g] = pending[g] && (lane_addr[g][ADDR_W-1:OFF_W] == LINE_W'(line));
    end

endmodule

// File: rtl/acu_top.sv
module acu_top
    import acu_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 32,
    parameter int ELEM_BYTES = 4,
    parameter int FIFO_DEPTH = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    output logic                                  in_ready,
    input  logic [LANES*ADDR_W-1:0]               in_addr,
    input  logic [LANES-1:0]                      in_mask,
    input  logic                                  in_store,
    output logic                                  out_valid,
    input  logic                                  out_ready,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  out_line,
    output logic [LANES-1:0]                      out_lanes,
    output logic [1:0]                            out_kind,
    output logic                                  out_store,
    output logic                                  done
);
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int LINE_W  = ADDR_W - OFF_W;
    localparam int ADDR_VW = LANES * ADDR_W;
    localparam int ENTRY_W = ADDR_VW + LANES + 1;

    acu_state_e           state_q, state_d;
    logic [ADDR_VW-1:0]   work_addr;
    logic [LANES-1:0]     pending_q;
    logic                 store_q;
    acu_kind_e            kind_q, cls_kind;
    logic [ENTRY_W-1:0]   head;
    logic                 q_not_empty, pop_en;
    logic [LINE_W-1:0]    grp_line;
    logic [LANES-1:0]     grp_lanes, left_after;

    acu_req_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (FIFO_DEPTH)
    ) req_q_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (in_valid),
        .push_ready (in_ready),
        .push_data  ({in_store, in_mask, in_addr}),
        .pop_en     (pop_en),
        .pop_data   (head),
        .not_empty  (q_not_empty)
    );

    acu_classify #(
        .LANES      (LANES),
        .ADDR_W     (ADDR_W),
        .ELEM_BYTES (ELEM_BYTES)
    ) cls_i (
        .addr_flat (work_addr),
        .mask      (pending_q),
        .kind      (cls_kind)
    );

    acu_group #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) grp_i (
        .addr_flat (work_addr),
        .pending   (pending_q),
        .line      (grp_line),
        .lanes     (grp_lanes)
    );

    assign pop_en     = (state_q == ST_IDLE) && q_not_empty;
    assign left_after = pending_q & ~grp_lanes;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (q_not_empty) state_d = ST_LOAD;
            ST_LOAD:   state_d = (pending_q == '0) ? ST_FINISH : ST_EMIT;
            ST_EMIT:   if (out_ready && left_after == '0) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Working registers of the request being split
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_addr <= '0;
            pending_q <= '0;
            store_q   <= 1'b0;
            kind_q    <= KIND_IRREG;
        end else begin
            unique case (state_q)
                ST_IDLE: if (q_not_empty) begin
                    work_addr <= head[ADDR_VW-1:0];
                    pending_q <= head[ADDR_VW +: LANES];
                    store_q   <= head[ENTRY_W-1];
                end
                ST_LOAD: kind_q <= cls_kind;
                ST_EMIT: if (out_ready) pending_q <= left_after;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        out_valid = (state_q == ST_EMIT);
        done      = (state_q == ST_FINISH);
        out_line  = grp_line;
        out_lanes = grp_lanes;
        out_kind  = kind_q;
        out_store = store_q;
    end

endmodule

// File: rtl/acu_checker.sv
module acu_checker #(
    parameter int LANES  = 8,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [LINE_W-1:0] out_line,
    input logic [LANES-1:0]  out_lanes,
    input logic [1:0]        out_kind,
    input logic              out_store,
    input logic              done
);
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_line) && $stable(out_lanes)
                                    && $stable(out_kind) && $stable(out_store));

    a_r10_lanes_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_lanes != '0);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready) || !$past(out_valid));

endmodule

bind acu_top acu_checker #(
    .LANES  (LANES),
    .LINE_W (ADDR_W - $clog2(LINE_BYTES))
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_line  (out_line),
    .out_lanes (out_lanes),
    .out_kind  (out_kind),
    .out_store (out_store),
    .done      (done)
);

// File: tb/acu_top_tb.sv
module acu_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 8;
    localparam int ADDR_W     = 16;
    localparam int LINE_BYTES = 32;
    localparam int ELEM_BYTES = 4;
    localparam int OFF_W      = 5;
    localparam int LINE_W     = ADDR_W - OFF_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [LANES*ADDR_W-1:0] in_addr = '0;
    logic [LANES-1:0]        in_mask = '0;
    logic                    in_store = 1'b0;
    logic                    out_valid;
    logic                    out_ready = 1'b1;
    logic [LINE_W-1:0]       out_line;
    logic [LANES-1:0]        out_lanes;
    logic [1:0]              out_kind;
    logic                    out_store;
    logic                    done;

    acu_top #(
        .LANES (LANES), .ADDR_W (ADDR_W), .LINE_BYTES (LINE_BYTES),
        .ELEM_BYTES (ELEM_BYTES), .FIFO_DEPTH (2)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_addr (in_addr), .in_mask (in_mask), .in_store (in_store),
        .out_valid (out_valid), .out_ready (out_ready), .out_line (out_line),
        .out_lanes (out_lanes), .out_kind (out_kind), .out_store (out_store), .done (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    // Stimulus of the request under test
    logic [ADDR_W-1:0] t_addr [LANES];
    logic [LANES-1:0]  t_mask;
    logic              t_store;

    // Expected transactions
    logic [LINE_W-1:0] exp_line  [64];
    logic [LANES-1:0]  exp_lanes [64];
    int                exp_n;
    logic [1:0]        exp_kind;

    // Recorded transactions
    logic [LINE_W-1:0] rec_line  [64];
    logic [LANES-1:0]  rec_lanes [64];
    logic [1:0]        rec_kind  [64];
    logic              rec_store [64];
    int                rec_n = 0;
    int                done_n = 0;

    // Output-side control
    logic       stall_rand = 1'b0;
    logic       hold_off   = 1'b0;
    logic [7:0] lfsr       = 8'h5A;
    logic       prev_hold  = 1'b0;
    logic [LINE_W-1:0] prev_line;
    logic [LANES-1:0]  prev_lanes;

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: set ready for the coming edge, then sample away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold) begin
                check(out_valid && out_line == prev_line && out_lanes == prev_lanes,
                      "R6", "held transaction", {out_line, out_lanes}, {prev_line, prev_lanes});
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = hold_off ? 1'b0 : (stall_rand ? lfsr[0] : 1'b1);
            prev_hold  = out_valid && !out_ready;
            prev_line  = out_line;
            prev_lanes = out_lanes;
            if (out_valid && out_ready && rec_n < 64) begin
                rec_line[rec_n]  = out_line;
                rec_lanes[rec_n] = out_lanes;
                rec_kind[rec_n]  = out_kind;
                rec_store[rec_n] = out_store;
                rec_n++;
            end
            if (done) done_n++;
        end
    end

    // Reference grouping and labelling from the requirements
    task automatic model();
        logic [LANES-1:0]  left;
        logic [ADDR_W-1:0] base, step, want;
        int                seen;
        logic              uni;
        left  = t_mask;
        exp_n = 0;
        for (int i = 0; i < LANES; i++) begin
            if (left[i]) begin
                exp_line[exp_n]  = t_addr[i][ADDR_W-1:OFF_W];
                exp_lanes[exp_n] = '0;
                for (int j = i; j < LANES; j++) begin
                    if (left[j] && t_addr[j][ADDR_W-1:OFF_W] == t_addr[i][ADDR_W-1:OFF_W]) begin
                        exp_lanes[exp_n][j] = 1'b1;
                        left[j] = 1'b0;
                    end
                end
                exp_n++;
            end
        end
        seen = 0; base = '0; step = '0; want = '0; uni = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (t_mask[i]) begin
                if (seen == 0) begin base = t_addr[i]; want = t_addr[i]; end
                else if (seen == 1) step = t_addr[i] - base;
                seen++;
            end
        end
        for (int i = 0; i < LANES; i++) begin
            if (t_mask[i]) begin
                if (t_addr[i] != want) uni = 1'b0;
                want = want + step;
            end
        end
        if (seen < 2)                       exp_kind = 2'd1;
        else if (!uni)                      exp_kind = 2'd0;
        else if (step == ADDR_W'(ELEM_BYTES)) exp_kind = 2'd1;
        else if (step == '0)                exp_kind = 2'd3;
        else                                exp_kind = 2'd2;
    endtask

    task automatic push();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < LANES; i++) in_addr[i*ADDR_W +: ADDR_W] = t_addr[i];
        in_mask  = t_mask;
        in_store = t_store;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done(input int target, input string req);
        int guard = 0;
        while (done_n < target && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(done_n >= target, req, "done pulses", done_n, target);
        @(negedge clk);
    endtask

    task automatic run_req(input string req);
        int d0;
        model();
        rec_n = 0;
        d0 = done_n;
        push();
        wait_done(d0 + 1, req);
        check(done_n == d0 + 1, "R7", "single done", done_n - d0, 1);
        check(rec_n == exp_n, req, "transaction count", rec_n, exp_n);
        for (int k = 0; k < exp_n && k < rec_n; k++) begin
            check(rec_line[k] == exp_line[k], req, "line", rec_line[k], exp_line[k]);
            check(rec_lanes[k] == exp_lanes[k], req, "lanes", rec_lanes[k], exp_lanes[k]);
            check(rec_kind[k] == exp_kind, "R5", "kind", rec_kind[k], exp_kind);
            check(rec_store[k] == t_store, "R8", "store", rec_store[k], t_store);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(!out_valid, "R9", "out_valid", out_valid, 0);
        check(!done, "R9", "done", done, 0);
        check(in_ready, "R9", "in_ready", in_ready, 1);
    endtask

    task automatic test_seq_aligned();     // R2 R5: one line, label 1
        for (int i = 0; i < LANES; i++) t_addr[i] = 16'h0100 + 16'(4*i);
        t_mask = 8'hFF; t_store = 1'b0;
        run_req("R2");
        check(rec_n == 1 && rec_lanes[0] == 8'hFF, "R2", "one full line", rec_lanes[0], 8'hFF);
    endtask

    task automatic test_seq_misaligned();  // R2 R4: two lines, lane order
        for (int i = 0; i < LANES; i++) t_addr[i] = 16'h0110 + 16'(4*i);
        t_mask = 8'hFF; t_store = 1'b1;
        run_req("R4");
        check(rec_lanes[0] == 8'h0F && rec_lanes[1] == 8'hF0, "R4", "split halves",
              {rec_lanes[0], rec_lanes[1]}, 16'h0FF0);
    endtask

    task automatic test_stride_stall();    // R2 R5 R6 under random ready
        for (int i = 0; i < LANES; i++) t_addr[i] = 16'h0800 + 16'(64*i);
        t_mask = 8'hFF; t_store = 1'b0;
        stall_rand = 1'b1;
        run_req("R6");
        stall_rand = 1'b0;
        check(exp_kind == 2'd2 && rec_n == 8, "R5", "stride lines", rec_n, 8);
    endtask

    task automatic test_same_addr();       // R5 label 3
        for (int i = 0; i < LANES; i++) t_addr[i] = 16'h0A40;
        t_mask = 8'hFF; t_store = 1'b1;
        run_req("R5");
    endtask

    task automatic test_irregular();       // R2 R4 scattered lines
        t_addr[0] = 16'h0200; t_addr[1] = 16'h0040; t_addr[2] = 16'h0210; t_addr[3] = 16'h1000;
        t_addr[4] = 16'h0044; t_addr[5] = 16'h3000; t_addr[6] = 16'h0400; t_addr[7] = 16'h021C;
        t_mask = 8'hFF; t_store = 1'b0;
        run_req("R4");
        check(rec_n == 5 && rec_lanes[0] == 8'h85 && rec_lanes[1] == 8'h12, "R4", "leader order",
              {rec_lanes[0], rec_lanes[1]}, 16'h8512);
    endtask

    task automatic test_inactive_ignored(); // R3: garbage in masked lanes
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < LANES; i++) t_addr[i] = (pass == 0) ? 16'h5000 + 16'(i*256) : 16'hF0F0 - 16'(i*8);
            t_addr[0] = 16'h0300; t_addr[2] = 16'h0304; t_addr[5] = 16'h0308; t_addr[7] = 16'h030C;
            t_mask = 8'hA5; t_store = 1'b0;
            run_req("R3");
            check(rec_n == 1 && rec_lanes[0] == 8'hA5 && rec_kind[0] == 2'd1, "R3",
                  "masked lanes unseen", rec_lanes[0], 8'hA5);
        end
    endtask

    task automatic test_empty_mask();      // R7 no lanes, still done
        for (int i = 0; i < LANES; i++) t_addr[i] = 16'h0700;
        t_mask = 8'h00; t_store = 1'b0;
        run_req("R7");
        check(rec_n == 0, "R7", "no transaction", rec_n, 0);
    endtask

    task automatic test_single_lane();     // R5 one active lane is sequential
        for (int i = 0; i < LANES; i++) t_addr[i] = 16'h1234 + 16'(i*100);
        t_mask = 8'h40; t_store = 1'b1;
        run_req("R5");
    endtask

    task automatic test_queue_full();      // R1 R8: fill queue behind a stalled engine
        int d0;
        hold_off = 1'b1;
        @(negedge clk);
        rec_n = 0;
        d0 = done_n;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < LANES; i++) t_addr[i] = 16'(16'h2000 + r*16'h0100 + 4*i);
            t_mask = 8'hFF; t_store = r[0];
            push();
        end
        check(!in_ready, "R1", "in_ready when queue full", in_ready, 0);
        hold_off = 1'b0;
        wait_done(d0 + 3, "R1");
        check(rec_n == 3, "R1", "queued count", rec_n, 3);
        for (int r = 0; r < 3 && r < rec_n; r++) begin
            check(rec_line[r] == LINE_W'((16'h2000 + r*16'h0100) >> OFF_W), "R1", "arrival order",
                  rec_line[r], (16'h2000 + r*16'h0100) >> OFF_W);
            check(rec_store[r] == r[0], "R8", "store per request", rec_store[r], r[0]);
        end
        check(in_ready, "R1", "in_ready after drain", in_ready, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_seq_aligned();
        test_seq_misaligned();
        test_stride_stall();
        test_same_addr();
        test_irregular();
        test_inactive_ignored();
        test_empty_mask();
        test_single_lane();
        test_queue_full();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule